// File: doc/BRIEF.md
# FM Line-Code Cassette Transmitter

This block turns a stream of bytes into a frequency-modulated line code on one output pin, for recording on audio tape. Every bit cell starts with a level change. A cell that carries a 1 has a second level change at its midpoint. A cell that carries a 0 has only the one at its start. The line level carries over from one cell to the next and from one byte to the next. The coder therefore inverts each group of samples when the level last sent was high.

Bytes enter through a valid/ready handshake into a one-byte holding register. Each byte is cut into groups of two bits. Each group becomes an eight-sample pattern, so every data bit spans four line samples. A 12-bit clock divider paces the samples.

Writing a divider value does two things. It starts the transmitter, and it first sends one idle pattern at the current line level. A configuration write is taken only while the block reports that it is drained.

Top module: `fm_cassette_tx`

## Requirements
- R1: While reset is high and on the cycle after it, `line_o` is 0, `in_ready` is 0 and `drained_o` is 1.
- R2: A taken configuration write sets the sample period to `cfg_rate`+1 clock cycles. If `cfg_rate` is above 4095, the period becomes `DEFAULT_DIV`+1 (3 cycles by default) instead.
- R3: After a taken configuration write, the line first carries 8 samples equal to the current line level, before any data sample. `drained_o` is low during them.
- R4: Each data bit occupies 4 samples. The first two samples are the inverse of the level before the cell. The last two equal the first two for a 0 bit, and are their inverse for a 1 bit.
- R5: Bits of a byte go out starting at bit 0 and ending at bit 7.
- R6: The line level carries across pattern and byte boundaries. Bytes written early enough follow each other with no idle sample between them.
- R7: `in_ready` is high only when the block is configured and the holding register is empty. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is low on the cycle after.
- R8: When no byte is waiting, the line holds its last level and changes only on a sample tick.
- R9: `drained_o` rises one sample period after the last data sample starts, and only when the holding register is empty. While it is high the line does not change.
- R10: A configuration write while `drained_o` is low is ignored. The sample period and the output stream are unchanged.
- R11: Reset returns the remembered line level to 0, so the next idle pattern is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rate | input | RATE_W (16) | Requested divider; sample period is this value plus one clock |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The holding register can take a byte |
| in_data | input | DATA_W (8) | Byte to send |
| line_o | output | 1 | Coded line output |
| drained_o | output | 1 | All output finished and nothing pending |

## Verification
The bench goes after level continuity across bytes and across rate changes. It picks byte pairs with an odd count of zero bits, so that the line ends high and the next idle pattern must come out all ones. A design that reset its level or dropped the inversion would put out zeros there.

It requests a divider above 4095. A design that truncated the value instead of substituting the default would pace samples at the wrong period, which shows up at once as misplaced samples.

It also writes a new rate while bytes are still going out. A design that accepted that write would change the pacing or insert an idle pattern mid-stream.

Finally, it watches the drained flag around the last sample. A design that raised the flag as soon as the last sample began would fail the check one period early.

// File: rtl/fm_tx_pkg.sv
package fm_tx_pkg;
   // source of the next pattern loaded into the sample shifter
   typedef enum logic [1:0] {
      SRC_IDLE = 2'd0,
      SRC_PRE  = 2'd1,
      SRC_CUR  = 2'd2,
      SRC_HOLD = 2'd3
   } fm_src_e;
endpackage

// File: rtl/fm_rate_gen.sv
module fm_rate_gen #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [DIV_W-1:0] div_i,
   input  logic             run,
   output logic [DIV_W-1:0] div_o,
   output logic             tick
);
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;

   assign tick  = run && (cnt_q == div_q);
   assign div_o = div_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         div_q <= '0;
         cnt_q <= '0;
      end else if (load) begin
         div_q <= div_i;
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= tick ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/fm_cell_coder.sv
module fm_cell_coder #(
   parameter int BITS = 2,
   parameter int SPB  = 4
) (
   input  logic [BITS-1:0]     bits_i,
   input  logic                lvl_i,
   output logic [BITS*SPB-1:0] pat_o,
   output logic                lvl_o
);
   localparam int HALF = SPB / 2;

   logic [BITS:0] lv;
   assign lv[0] = lvl_i;

   // each cell opens with a level change; a 1 adds one at mid-cell
   for (genvar g = 0; g < BITS; g++) begin : g_cell
      assign pat_o[g*SPB +: HALF]      = {HALF{~lv[g]}};
      assign pat_o[g*SPB+HALF +: HALF] = {HALF{bits_i[g] ? lv[g] : ~lv[g]}};
      assign lv[g+1]                   = bits_i[g] ? lv[g] : ~lv[g];
   end

   assign lvl_o = lv[BITS];
endmodule

// File: rtl/fm_sample_shifter.sv
module fm_sample_shifter #(
   parameter int PAT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             load,
   input  logic [PAT_W-1:0] pat_i,
   output logic             line_o,
   output logic             empty_o
);
   localparam int REM_W = $clog2(PAT_W + 1);

   logic [PAT_W-1:0] sr_q;
   logic [REM_W-1:0] rem_q;
   logic             line_q;

   assign empty_o = (rem_q == '0);
   assign line_o  = line_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sr_q   <= '0;
         rem_q  <= '0;
         line_q <= 1'b0;
      end else if (tick) begin
         if (empty_o && load) begin
            line_q <= pat_i[0];
            sr_q   <= pat_i >> 1;
            rem_q  <= REM_W'(PAT_W - 1);
         end else if (!empty_o) begin
            line_q <= sr_q[0];
            sr_q   <= sr_q >> 1;
            rem_q  <= rem_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/fm_cassette_tx.sv
module fm_cassette_tx
   import fm_tx_pkg::*;
#(
   parameter int DATA_W          = 8,
   parameter int BITS_PER_PAT    = 2,
   parameter int SAMPLES_PER_BIT = 4,
   parameter int DIV_W           = 12,
   parameter int RATE_W          = 16,
   parameter int DEFAULT_DIV     = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [RATE_W-1:0] cfg_rate,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              line_o,
   output logic              drained_o
);
   localparam int PAT_W   = BITS_PER_PAT * SAMPLES_PER_BIT;
   localparam int PPB     = DATA_W / BITS_PER_PAT;
   localparam int PC_W    = $clog2(PPB + 1);
   localparam int DIV_MAX = (1 << DIV_W) - 1;

   if (DATA_W % BITS_PER_PAT != 0) begin : g_bad_split
      $error("DATA_W must be a multiple of BITS_PER_PAT");
   end
   if (SAMPLES_PER_BIT < 2 || SAMPLES_PER_BIT % 2 != 0) begin : g_bad_spb
      $error("SAMPLES_PER_BIT must be even and at least 2");
   end
   if (RATE_W <= DIV_W) begin : g_bad_rate
      $error("RATE_W must exceed DIV_W");
   end
   if (DEFAULT_DIV > DIV_MAX) begin : g_bad_default
      $error("DEFAULT_DIV does not fit the divider");
   end

   logic              configured, pre_pend, hold_full, tx_done, level;
   logic [DATA_W-1:0] hold_byte, cur_byte;
   logic [PC_W-1:0]   pairs_left;
   logic              tick, sh_empty, slot, cfg_ok, accept;
   logic [DIV_W-1:0]  div_next, div_cur;
   fm_src_e           sel;
   logic [BITS_PER_PAT-1:0] code_bits;
   logic [PAT_W-1:0]  code_pat, load_pat;
   logic              code_lvl;

   assign drained_o = tx_done && !hold_full && (pairs_left == '0) && !pre_pend;
   assign in_ready  = configured && !hold_full;
   assign accept    = in_valid && in_ready;
   assign cfg_ok    = cfg_we && drained_o;
   assign div_next  = (cfg_rate > RATE_W'(DIV_MAX)) ? DIV_W'(DEFAULT_DIV)
                                                    : cfg_rate[DIV_W-1:0];
   assign slot      = tick && sh_empty;

   always_comb begin
      if (pre_pend)               sel = SRC_PRE;
      else if (pairs_left != '0)  sel = SRC_CUR;
      else if (hold_full)         sel = SRC_HOLD;
      else                        sel = SRC_IDLE;
   end

   assign code_bits = (sel == SRC_HOLD) ? hold_byte[BITS_PER_PAT-1:0]
                                        : cur_byte[BITS_PER_PAT-1:0];
   assign load_pat  = (sel == SRC_PRE) ? {PAT_W{level}} : code_pat;

   fm_rate_gen #(.DIV_W(DIV_W)) u_rate (
      .clk   (clk),
      .rst   (rst),
      .load  (cfg_ok),
      .div_i (div_next),
      .run   (configured),
      .div_o (div_cur),
      .tick  (tick)
   );

   fm_cell_coder #(.BITS(BITS_PER_PAT), .SPB(SAMPLES_PER_BIT)) u_coder (
      .bits_i (code_bits),
      .lvl_i  (level),
      .pat_o  (code_pat),
      .lvl_o  (code_lvl)
   );

   fm_sample_shifter #(.PAT_W(PAT_W)) u_shift (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .load    (sel != SRC_IDLE),
      .pat_i   (load_pat),
      .line_o  (line_o),
      .empty_o (sh_empty)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         configured <= 1'b0;
         pre_pend   <= 1'b0;
         hold_full  <= 1'b0;
         hold_byte  <= '0;
         cur_byte   <= '0;
         pairs_left <= '0;
         level      <= 1'b0;
         tx_done    <= 1'b1;
      end else begin
         if (cfg_ok) begin
            configured <= 1'b1;
            pre_pend   <= 1'b1;
         end
         if (accept) begin
            hold_full <= 1'b1;
            hold_byte <= in_data;
         end
         if (slot) begin
            unique case (sel)
               SRC_PRE: begin
                  pre_pend <= 1'b0;
                  tx_done  <= 1'b0;
               end
               SRC_CUR: begin
                  cur_byte   <= cur_byte >> BITS_PER_PAT;
                  pairs_left <= pairs_left - 1'b1;
                  level      <= code_lvl;
                  tx_done    <= 1'b0;
               end
               SRC_HOLD: begin
                  cur_byte   <= hold_byte >> BITS_PER_PAT;
                  pairs_left <= PC_W'(PPB - 1);
                  hold_full  <= 1'b0;
                  level      <= code_lvl;
                  tx_done    <= 1'b0;
               end
               default: tx_done <= 1'b1;
            endcase
         end
      end
   end
endmodule

// File: rtl/fm_tx_checker.sv
module fm_tx_checker #(
   parameter int RATE_W      = 16,
   parameter int DIV_W       = 12,
   parameter int DEFAULT_DIV = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              cfg_we,
   input logic [RATE_W-1:0] cfg_rate,
   input logic              in_valid,
   input logic              in_ready,
   input logic              line_o,
   input logic              drained_o,
   input logic              tick,
   input logic [DIV_W-1:0]  div_cur
);
   localparam int DIV_MAX = (1 << DIV_W) - 1;

   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (!line_o && !in_ready && drained_o));

   a_r2_default_rate: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && drained_o && (cfg_rate > RATE_W'(DIV_MAX)))
         |=> (div_cur == DIV_W'(DEFAULT_DIV)));

   a_r7_single_hold: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !in_ready);

   a_r8_line_on_tick: assert property (@(posedge clk) disable iff (rst)
      !$stable(line_o) |-> $past(tick));

   a_r9_drained_quiet: assert property (@(posedge clk) disable iff (rst)
      drained_o |=> $stable(line_o));

   a_r10_busy_cfg: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && !drained_o) |=> $stable(div_cur));
endmodule

bind fm_cassette_tx fm_tx_checker #(
   .RATE_W      (RATE_W),
   .DIV_W       (DIV_W),
   .DEFAULT_DIV (DEFAULT_DIV)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cfg_we    (cfg_we),
   .cfg_rate  (cfg_rate),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .line_o    (line_o),
   .drained_o (drained_o),
   .tick      (tick),
   .div_cur   (div_cur)
);

// File: tb/tb_fm_cassette_tx.sv
module tb_fm_cassette_tx;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 4;
   // {rate[15:0], expected divider[7:0], byte0, byte1}
   localparam logic [39:0] VEC [NVEC] = '{
      {16'd1,      8'd1, 8'hA5, 8'h3C},
      {16'd3,      8'd3, 8'hFE, 8'h00},
      {16'h1000,   8'd2, 8'h01, 8'h80},
      {16'd0,      8'd0, 8'h5A, 8'hC3}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_rate = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = '0;
   logic        line_o;
   logic        drained_o;

   int checks = 0;
   int fails  = 0;
   logic lvl = 1'b0;
   logic exp_s [0:127];
   int   nexp;
   bit   finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fm_cassette_tx dut (
      .clk (clk), .rst (rst), .cfg_we (cfg_we), .cfg_rate (cfg_rate),
      .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
      .line_o (line_o), .drained_o (drained_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic build_expect(input logic [7:0] b0, input logic [7:0] b1);
      logic [15:0] bits = {b1, b0};
      logic l = lvl;
      nexp = 0;
      for (int i = 0; i < 8; i++) begin exp_s[nexp] = l; nexp++; end
      for (int i = 0; i < 16; i++) begin
         l = ~l;
         exp_s[nexp] = l; exp_s[nexp+1] = l; nexp += 2;
         if (bits[i]) l = ~l;
         exp_s[nexp] = l; exp_s[nexp+1] = l; nexp += 2;
      end
      lvl = l;
   endtask

   task automatic do_cfg(input logic [15:0] rate);
      @(negedge clk);
      cfg_we = 1'b1; cfg_rate = rate;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      in_valid = 1'b1; in_data = b;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(in_ready == 1'b0, "R7 ready after take", int'(in_ready), 0);
   endtask

   task automatic capture(input int d);
      for (int k = 0; k < nexp; k++) begin
         repeat (d + 1) @(posedge clk);
         @(negedge clk);
         if (k == 0) check(drained_o == 1'b0, "R3 busy in idle pattern", int'(drained_o), 0);
         if (k < 8) check(line_o == exp_s[k], "R3 idle pattern sample", int'(line_o), int'(exp_s[k]));
         else       check(line_o == exp_s[k], "R4 R5 R6 R2 data sample", int'(line_o), int'(exp_s[k]));
      end
      check(drained_o == 1'b0, "R9 last sample still out", int'(drained_o), 0);
      repeat (d + 1) @(posedge clk);
      @(negedge clk);
      check(drained_o == 1'b1, "R9 drained after last", int'(drained_o), 1);
      check(line_o == lvl, "R8 line holds", int'(line_o), int'(lvl));
      repeat (3 * (d + 1)) @(posedge clk);
      @(negedge clk);
      check(line_o == lvl, "R8 line still holds", int'(line_o), int'(lvl));
   endtask

   task automatic run_stream(input logic [15:0] rate, input int d,
                             input logic [7:0] b0, input logic [7:0] b1, input bit busy_cfg);
      build_expect(b0, b1);
      do_cfg(rate);
      fork
         begin send(b0); send(b1); end
         capture(d);
         begin
            if (busy_cfg) begin
               repeat (20) @(negedge clk);
               cfg_we = 1'b1; cfg_rate = 16'd5;   // R10: must be ignored
               @(negedge clk);
               cfg_we = 1'b0;
            end
         end
      join
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      end
      $finish;
   end

   initial begin
      in_valid = 1'b1; in_data = 8'h77;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(line_o == 1'b0, "R1 line in reset", int'(line_o), 0);
      check(in_ready == 1'b0, "R1 ready in reset", int'(in_ready), 0);
      check(drained_o == 1'b1, "R1 drained in reset", int'(drained_o), 1);
      rst = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(in_ready == 1'b0, "R7 not ready before config", int'(in_ready), 0);
      end
      in_valid = 1'b0;

      for (int v = 0; v < NVEC; v++) begin
         run_stream(VEC[v][39:24], int'(VEC[v][23:16]), VEC[v][15:8], VEC[v][7:0], 1'b0);
      end

      // R10: rate write during streaming is ignored; level is 1 here
      run_stream(16'd1, 1, 8'h12, 8'h33, 1'b1);

      // R11: reset clears the carried level
      check(line_o == 1'b1, "R11 line high before reset", int'(line_o), 1);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      check(line_o == 1'b0, "R11 line after reset", int'(line_o), 0);
      check(in_ready == 1'b0, "R11 ready after reset", int'(in_ready), 0);
      check(drained_o == 1'b1, "R11 drained after reset", int'(drained_o), 1);
      lvl = 1'b0;
      run_stream(16'd2, 2, 8'hF0, 8'h0F, 1'b0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule